// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that keeps a small bank of 8-bit configuration bytes for a clock generator. The byte outputs feed the frequency selection, spread-spectrum, output-enable and stop logic next to it. A host changes the bank with a block write. Address byte 0xD2 starts a write. The slave then acknowledges a command byte and a count byte and discards both. The data bytes that follow are stored from byte 0 upward. A stop may end the transfer after any complete byte. A block read starts with address byte 0xD3. The slave returns a byte count first and then the stored bytes in ascending order.

Both bus lines are open-drain. The slave only ever pulls data low, through `sda_oe`. Each line passes through a two-flop synchronizer and a glitch filter clocked by the system clock. All bus decoding works on the filtered copies. The system clock must be many times faster than the bus, which runs at up to 100 kbit/s.

The controller is a state machine with eight states:

| State | Role |
|---|---|
| IDLE | Waits for a start condition. |
| ADDR | Shifts in the address byte. |
| ADDR_ACK | Drives the acknowledge for a matching address. |
| WR_BYTE | Shifts in a write byte. |
| WR_ACK | Acknowledges a write byte. |
| RD_BYTE | Shifts out a read byte, MSB first. |
| RD_ACK | Samples the host's acknowledge. |
| IGNORE | Stays silent until the next start or stop. |

Transitions:
- A stop sends any state to IDLE.
- A start, including a repeated start, sends any state to ADDR.
- ADDR goes to ADDR_ACK on a match and to IGNORE otherwise. This happens at the SCL fall that follows the eighth bit.
- ADDR_ACK goes to RD_BYTE or to WR_BYTE, chosen by the read/write bit.
- WR_BYTE goes to WR_ACK after eight bits, and WR_ACK returns to WR_BYTE.
- RD_BYTE goes to RD_ACK after eight bits.
- RD_ACK goes to RD_BYTE on a host acknowledge and to IGNORE on a not-acknowledge.

Top module: `cfg_serial_slave`

## Requirements
- R1: Address byte 0xD2 (write) and address byte 0xD3 (read) are acknowledged. Any other address byte gets no acknowledge, and the rest of that transfer has no effect on the bank or on `sda_oe`.
- R2: In a write, the two bytes after the address are a command byte and a count byte. Both are acknowledged, and their values never reach the bank.
- R3: The write data bytes after those two are stored into byte 0, byte 1, and so on, in arrival order. Each one is acknowledged. A stored byte appears on `cfg_bytes[8*i +: 8]` before the acknowledge clock of that byte.
- R4: A stop after any complete data byte leaves all higher bytes unchanged. A data byte cut short by a stop is discarded.
- R5: Data bytes beyond byte 6 (the last of the 7 bytes) are acknowledged and discarded.
- R6: A read returns the count 0x07 first, then bytes 0 through 6, each MSB first. Any byte read past byte 6 is 0x00. A host not-acknowledge ends the slave's driving.
- R7: After reset, byte 0 is 0x00, bytes 1 to 5 (the output enables) are 0xFF, and byte 6 is 0x00. In byte 0, bit 7 selects down spread (1) or center spread (0), and bit 1 enables spread.
- R8: Until byte 0 is written after reset, a read of byte 0 replaces bits 6:4 with revision bits 001 and bit 2 with 0, so it reads 0x10 after reset. After byte 0 is written, a read returns the stored value.
- R9: A pulse on SCL shorter than three system clocks is filtered out and neither adds nor removes a bit.
- R10: A repeated start restarts the address phase, and a read can follow a write without a stop between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| cfg_bytes | output | 56 | Configuration bytes; byte i at bits 8*i+7 down to 8*i |

## Verification
The hardest state to reach from the ports is a filtered glitch. The bench injects a two-cycle high pulse on SCL in the middle of a low phase of a data bit. It then checks that the byte still lands unchanged and is still acknowledged, which shows that no bit was added by the pulse. A partial byte ended by a stop and a repeated start that turns a write into a read are built the same way: the bench controls the line levels bit by bit. A reference array of the bank, updated only when the bench's own view of the protocol says a write lands, is compared with the outputs on every clock outside the short window around each commit.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_e;

    // 7-bit device address: 0xD2 write / 0xD3 read
    localparam logic [6:0] DEF_DEV_ADDR = 7'h69;

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= 2'b11;
            run_q    <= '0;
            filt_out <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            if (sync_q[1] == filt_out) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                filt_out <= sync_q[1];
                run_q    <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        bus_start = scl_f & scl_q & sda_q & ~sda_f;
        bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int       NUM_BYTES = 7,
    parameter int       ENA_FIRST = 1,
    parameter int       ENA_LAST  = 5,
    parameter logic [3:0] REV_ID  = 4'b0001,
    localparam int      IDX_W     = $clog2(NUM_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_data,
    output logic [NUM_BYTES*8-1:0] bytes_flat
);
    logic [7:0] bank_q [NUM_BYTES];
    logic       b0_written_q;

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
        localparam logic [7:0] DEF = (gi >= ENA_FIRST && gi <= ENA_LAST) ? 8'hFF : 8'h00;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q[gi] <= DEF;
            else if (wr_en && wr_idx == IDX_W'(gi))
                bank_q[gi] <= wr_data;
        end
        assign bytes_flat[gi*8 +: 8] = bank_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            b0_written_q <= 1'b0;
        else if (wr_en && wr_idx == '0)
            b0_written_q <= 1'b1;
    end

    always_comb begin
        rd_data = bank_q[rd_idx];
        if (rd_idx == '0 && !b0_written_q)
            rd_data = {rd_data[7], REV_ID[2:0], rd_data[3], REV_ID[3], rd_data[1:0]};
    end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_slave_pkg::*;
#(
    parameter int         NUM_BYTES = 7,
    parameter int         FILT_LEN  = 4,
    parameter logic [6:0] DEV_ADDR  = DEF_DEV_ADDR,
    parameter logic [3:0] REV_ID    = 4'b0001,
    parameter int         ENA_FIRST = 1,
    parameter int         ENA_LAST  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    output logic [NUM_BYTES*8-1:0] cfg_bytes
);
    localparam int IDX_W = $clog2(NUM_BYTES);
    localparam int CNT_W = $clog2(NUM_BYTES + 2) + 2;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] HDR_LEN  = CNT_W'(2);
    localparam logic [CNT_W-1:0] LAST_WR  = CNT_W'(NUM_BYTES + 1);
    localparam logic [CNT_W-1:0] NB_CNT   = CNT_W'(NUM_BYTES);

    logic scl_filt, sda_filt;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    slv_state_e state, state_nx;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh, tx_sh;
    logic [CNT_W-1:0] wr_cnt, rd_ptr;
    logic             host_ack;

    logic             byte_in_done;
    logic             bank_we;
    logic [IDX_W-1:0] bank_widx, bank_ridx;
    logic [7:0]       bank_rdata, next_tx;
    logic [CNT_W-1:0] wr_off;

    line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_in(scl_in), .filt_out(scl_filt));
    line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_in(sda_in), .filt_out(sda_filt));

    bus_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_filt), .sda_f(sda_filt),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop));

    cfg_reg_bank #(
        .NUM_BYTES(NUM_BYTES), .ENA_FIRST(ENA_FIRST),
        .ENA_LAST(ENA_LAST), .REV_ID(REV_ID)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bank_we), .wr_idx(bank_widx), .wr_data(rx_sh),
        .rd_idx(bank_ridx), .rd_data(bank_rdata),
        .bytes_flat(cfg_bytes));

    // ---------------- datapath helpers ----------------
    always_comb begin
        byte_in_done = scl_fall && (bit_cnt == 4'd8);
        wr_off       = wr_cnt - HDR_LEN;
        bank_widx    = wr_off[IDX_W-1:0];
        bank_we      = (state == ST_WR_BYTE) && byte_in_done &&
                       (wr_cnt >= HDR_LEN) && (wr_cnt <= LAST_WR);
        bank_ridx    = rd_ptr[IDX_W-1:0];
        next_tx      = (rd_ptr < NB_CNT) ? bank_rdata : 8'h00;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        if (bus_stop) begin
            state_nx = ST_IDLE;
        end else if (bus_start) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_in_done)
                                 state_nx = (rx_sh[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nx = rx_sh[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_in_done) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt == 4'd7) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                                 state_nx = host_ack ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:   state_nx = ST_IGNORE;
            endcase
        end
    end

    // ---------------- shift / count datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            wr_cnt   <= '0;
            rd_ptr   <= '0;
            host_ack <= 1'b0;
        end else if (bus_start || bus_stop) begin
            bit_cnt <= '0;
            wr_cnt  <= '0;
            rd_ptr  <= '0;
        end else begin
            case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[6:0], sda_filt};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_in_done) begin
                        bit_cnt <= '0;
                        if (state == ST_WR_BYTE && wr_cnt != CNT_MAX)
                            wr_cnt <= wr_cnt + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        tx_sh   <= 8'(NUM_BYTES);
                        bit_cnt <= '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        bit_cnt <= (bit_cnt == 4'd7) ? 4'd0 : bit_cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise)
                        host_ack <= ~sda_filt;
                    if (scl_fall) begin
                        tx_sh <= next_tx;
                        if (rd_ptr != CNT_MAX)
                            rd_ptr <= rd_ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_sh[7];
            default:                sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
    import cfg_slave_pkg::*;
#(
    parameter int CFG_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_filt,
    input logic             sda_oe,
    input logic             bus_start,
    input logic             bus_stop,
    input slv_state_e       state,
    input logic [3:0]       bit_cnt,
    input logic [CFG_W-1:0] cfg_bytes
);
    // R6: the slave moves the data line only while SCL is low
    p_drive_low_scl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_filt);

    // R3: the bank never changes while SCL is high
    p_commit_low_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_bytes) |-> !scl_filt);

    // R4: a stop releases the data line on the next cycle
    p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);

    // R1: a transfer for another device never drives the line
    p_ignore_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R10: any start leads into the address phase
    p_start_to_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> (state == ST_ADDR));

    // R9: bit counter stays inside one byte plus its boundary
    p_bitcnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.CFG_W(NUM_BYTES*8)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_filt(scl_filt), .sda_oe(sda_oe),
    .bus_start(bus_start), .bus_stop(bus_stop), .state(state),
    .bit_cnt(bit_cnt), .cfg_bytes(cfg_bytes));

// File: tb/sim_cfg_serial_slave.sv
module sim_cfg_serial_slave;
    localparam int NB = 7;
    localparam int Q  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [NB*8-1:0] cfg_bytes;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] mdl [NB];
    bit         mdl_b0_wr = 1'b0;
    bit         cmp_en    = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    cfg_serial_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
        .sda_oe(sda_oe), .cfg_bytes(cfg_bytes));

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    // reference bank compared on every clock (R3 R4 R5 R7)
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            for (int i = 0; i < NB; i++)
                chk(cfg_bytes[i*8 +: 8] === mdl[i], "R3 bank byte", cfg_bytes[i*8 +: 8], mdl[i]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start();
        sda_drv = 1'b1; wq(Q); scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q); scl_drv = 1'b0; wq(Q);
    endtask

    task automatic b_stop();
        sda_drv = 1'b0; wq(Q); scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(2*Q);
    endtask

    task automatic wbit(input logic b, input bit glitch);
        sda_drv = b;
        if (glitch) begin
            wq(3); scl_drv = 1'b1; wq(2); scl_drv = 1'b0; wq(Q-5);
        end else begin
            wq(Q);
        end
        scl_drv = 1'b1; wq(2*Q); scl_drv = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
        cmp_en = 1'b0;
        for (int i = 7; i >= 0; i--) wbit(d[i], glitch && i == 4);
        sda_drv = 1'b1; wq(Q); scl_drv = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q); scl_drv = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            sda_drv = 1'b1; wq(Q); scl_drv = 1'b1; wq(Q);
            d = {d[6:0], sda_line};
            wq(Q); scl_drv = 1'b0; wq(Q);
        end
        sda_drv = ~give_ack; wq(Q); scl_drv = 1'b1; wq(2*Q);
        scl_drv = 1'b0; wq(Q); sda_drv = 1'b1;
    endtask

    function automatic logic [7:0] exp_rd(input int i);
        if (i >= NB) return 8'h00;
        if (i == 0 && !mdl_b0_wr)
            return {mdl[0][7], 3'b001, mdl[0][3], 1'b0, mdl[0][1:0]};
        return mdl[i];
    endfunction

    task automatic write_hdr();
        bit a;
        b_start();
        send_byte(8'hD2, 1'b0, a); chk(a, "R1 write address ack", 8'(a), 8'd1);
        send_byte(8'hA5, 1'b0, a); chk(a, "R2 command ack", 8'(a), 8'd1);
        send_byte(8'h03, 1'b0, a); chk(a, "R2 count ack", 8'(a), 8'd1);
        cmp_en = 1'b1;
    endtask

    task automatic write_data(input logic [7:0] dq[$], input bit glitch_first);
        bit a;
        foreach (dq[k]) begin
            send_byte(dq[k], glitch_first && k == 0, a);
            if (k < NB) begin
                chk(a, glitch_first && k == 0 ? "R9 glitched byte ack" : "R3 data ack", 8'(a), 8'd1);
                mdl[k] = dq[k];
                if (k == 0) mdl_b0_wr = 1'b1;
            end else begin
                chk(a, "R5 extra byte ack", 8'(a), 8'd1);
            end
            cmp_en = 1'b1;
        end
    endtask

    task automatic read_all();
        bit a;
        logic [7:0] d;
        b_start();
        send_byte(8'hD3, 1'b0, a); chk(a, "R1 read address ack", 8'(a), 8'd1);
        cmp_en = 1'b1;
        recv_byte(1'b1, d); chk(d == 8'h07, "R6 byte count", d, 8'h07);
        for (int i = 0; i <= NB; i++) begin
            recv_byte(i < NB, d);
            chk(d == exp_rd(i), i == 0 ? "R8 byte 0 readback" : "R6 read byte", d, exp_rd(i));
        end
        chk(sda_oe == 1'b0, "R6 released after nack", 8'(sda_oe), 8'd0);
        b_stop();
    endtask

    initial begin
        logic [7:0] q[$];
        logic [7:0] d;
        bit a;
        for (int i = 0; i < NB; i++) mdl[i] = (i >= 1 && i <= 5) ? 8'hFF : 8'h00;
        wq(5); rst_n = 1'b1; wq(2);
        for (int i = 0; i < NB; i++)
            chk(cfg_bytes[i*8 +: 8] == mdl[i], "R7 reset default", cfg_bytes[i*8 +: 8], mdl[i]);
        chk(sda_oe == 1'b0, "R7 line released", 8'(sda_oe), 8'd0);
        cmp_en = 1'b1;

        // read of defaults, revision override on byte 0
        read_all();

        // short write: two bytes, higher bytes untouched
        write_hdr();
        q = '{8'h82, 8'h3C};
        write_data(q, 1'b0);
        b_stop();
        chk(cfg_bytes[7] == 1'b1 && cfg_bytes[1] == 1'b1, "R7 spread down and enable bits",
            cfg_bytes[7:0], 8'h82);
        read_all();

        // full write with two surplus bytes
        write_hdr();
        q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
        write_data(q, 1'b0);
        b_stop();
        read_all();

        // foreign address ignored
        b_start();
        send_byte(8'hA0, 1'b0, a); chk(!a, "R1 foreign address nack", 8'(a), 8'd0);
        send_byte(8'h12, 1'b0, a); chk(!a, "R1 ignored byte nack", 8'(a), 8'd0);
        cmp_en = 1'b1;
        b_stop();

        // partial byte ended by stop
        write_hdr();
        for (int i = 0; i < 4; i++) wbit(1'b0, 1'b0);
        b_stop();
        chk(cfg_bytes[7:0] == 8'h11, "R4 partial byte discarded", cfg_bytes[7:0], 8'h11);

        // glitch on SCL during a data byte
        write_hdr();
        q = '{8'hC3};
        write_data(q, 1'b1);
        b_stop();
        chk(cfg_bytes[7:0] == 8'hC3, "R9 glitch filtered", cfg_bytes[7:0], 8'hC3);

        // write then repeated start into a read
        write_hdr();
        q = '{8'h5A};
        write_data(q, 1'b0);
        sda_drv = 1'b1; wq(Q); scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q); scl_drv = 1'b0; wq(Q);
        send_byte(8'hD3, 1'b0, a); chk(a, "R10 read after repeated start", 8'(a), 8'd1);
        cmp_en = 1'b1;
        recv_byte(1'b0, d); chk(d == 8'h07, "R10 count after repeated start", d, 8'h07);
        b_stop();
        chk(cfg_bytes[7:0] == 8'h5A, "R10 write before restart kept", cfg_bytes[7:0], 8'h5A);

        wq(20);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule